// File: doc/BRIEF.md
# Host Port Status and Vector Logic

This block is the host-side register set of a byte-wide parallel host port that sits in front of a 24-bit processor core. The host sees a small address space. It holds a control register, a status register, an interrupt vector register and three receive byte registers. Writes to the byte addresses load a 24-bit transmit word for the core.

The block raises an active-high host request whenever an enabled data condition is pending. One condition is a full receive word; the other is an empty transmit word. The status register reports that request together with a DMA-mode flag. During a vectored-interrupt acknowledge the block drives the vector byte onto the host data bus, but only when DMA mode is off.

There are four ways to clear state, and they differ. The asynchronous hardware reset and the synchronous software reset also restore the vector to 0x0F. The individual reset and stop mode leave the vector alone.

Top module: `hp_status_top`

## Requirements
- R1: Status bit 6 (DMA) reads 1 when either mode bit of the control register is 1, and 0 when both are 0. The control register is at address 0. Its bit 0 is the receive request enable, bit 1 the transmit request enable, bit 3 mode bit 0 and bit 4 mode bit 1.
- R2: `host_req_o` is 1 exactly when (receive-full and receive enable) or (transmit-empty and transmit enable). Status bit 7 reads the same value. The status register is at address 1: bit 0 is receive-full, bit 1 is transmit-empty, and the other bits read 0.
- R3: A one-cycle `core_rx_load_i` latches the word and sets receive-full. A host read strobe at address 5 (low byte) clears it. Reads at addresses 3 and 4 do not clear it.
- R4: Transmit-empty is 1 after reset. A host write strobe at address 5 clears it, and `core_tx_take_i` sets it again. Host writes at addresses 3, 4 and 5 load the high, middle and low bytes of `core_tx_word_o`.
- R5: The vector register at address 2 is read/write by the host. Hardware reset and software reset each load it with 0x0F.
- R6: Individual reset, stop mode and software reset each clear the control register and receive-full, and set transmit-empty. This leaves the DMA bit and the host request at 0. Individual reset and stop mode leave the vector register unchanged.
- R7: While `host_req_o`, `hack_i` and not-DMA all hold, `hd_oe_o` is 1 and `hd_o` carries the vector register. When DMA mode is on, an acknowledge does not enable the bus.
- R8: `hd_oe_o` is 0 unless a host read (`hcs_i` and `hrw_i`) or a vector acknowledge is in progress.
- R9: Addresses 3, 4 and 5 read bits 23:16, 15:8 and 7:0 of the received word. Host writes to these addresses do not change what they read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| soft_rst_i | input | 1 | Software reset, synchronous |
| indiv_rst_i | input | 1 | Individual reset, synchronous |
| stop_i | input | 1 | Stop mode, clears state while high |
| hcs_i | input | 1 | Host chip select |
| hstb_i | input | 1 | One-cycle access strobe |
| hrw_i | input | 1 | 1 = host read, 0 = host write |
| haddr_i | input | 3 | Host register address |
| hd_i | input | 8 | Host write data |
| hd_o | output | 8 | Host read / vector data |
| hd_oe_o | output | 1 | Host data bus drive enable |
| hack_i | input | 1 | Host interrupt acknowledge |
| host_req_o | output | 1 | Host request, active high |
| core_rx_load_i | input | 1 | Core loads a receive word |
| core_rx_word_i | input | 24 | Receive word from the core |
| core_tx_take_i | input | 1 | Core takes the transmit word |
| core_tx_word_o | output | 24 | Transmit word to the core |

## Verification
The request logic is tried with each enable alone against each flag, so that a swapped or ORed enable shows up as a wrong status bit 7. DMA status is tried with each mode bit set alone, which separates an OR from an AND or a single-bit decode. Receive bytes are read high, middle, then low, with a status read in between, which shows whether only the low read clears the flag. The four reset kinds are each applied after a non-default vector has been written, so a reset that touches the vector when it should not is visible on a read.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_STAT  = 1;
  localparam int unsigned ADDR_VEC   = 2;
  localparam int unsigned ADDR_BYTE0 = 3;  // high byte; word bytes follow

  localparam int unsigned CB_RXEN = 0;
  localparam int unsigned CB_TXEN = 1;
  localparam int unsigned CB_HM0  = 3;
  localparam int unsigned CB_HM1  = 4;

  localparam int unsigned SB_RXDF = 0;
  localparam int unsigned SB_TXDE = 1;
  localparam int unsigned SB_DMA  = 6;
  localparam int unsigned SB_REQ  = 7;
endpackage

// File: rtl/hp_regs.sv
module hp_regs #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              soft_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_vec_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic [1:0]        mode_o,
  output logic [DATA_W-1:0] vec_o
);
  import hp_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o <= 1'b0;
      tx_en_o <= 1'b0;
      mode_o  <= 2'b00;
      vec_o   <= VEC_RESET;
    end else begin
      if (clr_i) begin
        rx_en_o <= 1'b0;
        tx_en_o <= 1'b0;
        mode_o  <= 2'b00;
      end else if (wr_ctrl_i) begin
        rx_en_o <= wdata_i[CB_RXEN];
        tx_en_o <= wdata_i[CB_TXEN];
        mode_o  <= {wdata_i[CB_HM1], wdata_i[CB_HM0]};
      end
      // only hw/soft reset restore the vector
      if (soft_i)                  vec_o <= VEC_RESET;
      else if (!clr_i && wr_vec_i) vec_o <= wdata_i;
    end
  end
endmodule

// File: rtl/hp_data.sv
module hp_data #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORD_W = 24,
  localparam int unsigned NBYTES = WORD_W / DATA_W,
  localparam int unsigned BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rx_load_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              tx_take_i,
  input  logic              wr_byte_i,
  input  logic [BIDX_W-1:0] byte_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_low_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              rxdf_o,
  output logic              txde_o
);
  localparam logic [BIDX_W-1:0] LOW_IDX = BIDX_W'(NBYTES - 1);

  wire wr_low = wr_byte_i && !clr_i && (byte_idx_i == LOW_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_word_o <= '0;
    else if (rx_load_i) rx_word_o <= rx_word_i;
  end

  // byte 0 is the most significant
  for (genvar k = 0; k < NBYTES; k++) begin : g_tx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_word_o[WORD_W-1-k*DATA_W -: DATA_W] <= '0;
      else if (wr_byte_i && !clr_i && byte_idx_i == BIDX_W'(k))
        tx_word_o[WORD_W-1-k*DATA_W -: DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxdf_o <= 1'b0;
      txde_o <= 1'b1;
    end else if (clr_i) begin
      rxdf_o <= 1'b0;
      txde_o <= 1'b1;
    end else begin
      if (rx_load_i)     rxdf_o <= 1'b1;
      else if (rd_low_i) rxdf_o <= 1'b0;
      if (tx_take_i)     txde_o <= 1'b1;
      else if (wr_low)   txde_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hp_bus.sv
module hp_bus #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NBYTES = WORD_W / DATA_W
) (
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic [1:0]        mode_i,
  input  logic              rxdf_i,
  input  logic              txde_i,
  input  logic [DATA_W-1:0] vec_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_cyc_i,
  input  logic              hack_i,
  output logic [DATA_W-1:0] hd_o,
  output logic              hd_oe_o,
  output logic              req_o,
  output logic              dma_o
);
  import hp_pkg::*;

  logic [DATA_W-1:0] ctrl_rd, stat_rd, rd_data;
  logic ack_drive;

  always_comb begin
    dma_o     = |mode_i;
    req_o     = (rxdf_i && rx_en_i) || (txde_i && tx_en_i);
    ack_drive = req_o && hack_i && !dma_o;

    ctrl_rd          = '0;
    ctrl_rd[CB_RXEN] = rx_en_i;
    ctrl_rd[CB_TXEN] = tx_en_i;
    ctrl_rd[CB_HM0]  = mode_i[0];
    ctrl_rd[CB_HM1]  = mode_i[1];

    stat_rd          = '0;
    stat_rd[SB_RXDF] = rxdf_i;
    stat_rd[SB_TXDE] = txde_i;
    stat_rd[SB_DMA]  = dma_o;
    stat_rd[SB_REQ]  = req_o;

    rd_data = '0;
    case (int'(addr_i))
      ADDR_CTRL: rd_data = ctrl_rd;
      ADDR_STAT: rd_data = stat_rd;
      ADDR_VEC:  rd_data = vec_i;
      default:   rd_data = '0;
    endcase
    for (int k = 0; k < NBYTES; k++)
      if (int'(addr_i) == ADDR_BYTE0 + k)
        rd_data = rx_word_i[WORD_W-1-k*DATA_W -: DATA_W];

    hd_oe_o = ack_drive || rd_cyc_i;
    hd_o    = ack_drive ? vec_i : (rd_cyc_i ? rd_data : '0);
  end
endmodule

// File: rtl/hp_status_top.sv
module hp_status_top #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned ADDR_W = 3,
  parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F,
  localparam int unsigned NBYTES = WORD_W / DATA_W,
  localparam int unsigned BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              indiv_rst_i,
  input  logic              stop_i,
  input  logic              hcs_i,
  input  logic              hstb_i,
  input  logic              hrw_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [DATA_W-1:0] hd_i,
  output logic [DATA_W-1:0] hd_o,
  output logic              hd_oe_o,
  input  logic              hack_i,
  output logic              host_req_o,
  input  logic              core_rx_load_i,
  input  logic [WORD_W-1:0] core_rx_word_i,
  input  logic              core_tx_take_i,
  output logic [WORD_W-1:0] core_tx_word_o
);
  import hp_pkg::*;

  logic clr, acc, wr, rd, in_bytes, rd_low;
  logic rx_en, tx_en, dma_w, rxdf_w, txde_w;
  logic [1:0] mode;
  logic [DATA_W-1:0] vec_w;
  logic [WORD_W-1:0] rx_word;
  logic [BIDX_W-1:0] byte_idx;

  always_comb begin
    clr      = soft_rst_i || indiv_rst_i || stop_i;
    acc      = hcs_i && hstb_i;
    wr       = acc && !hrw_i;
    rd       = acc && hrw_i;
    in_bytes = (int'(haddr_i) >= ADDR_BYTE0) && (int'(haddr_i) < ADDR_BYTE0 + NBYTES);
    byte_idx = BIDX_W'(int'(haddr_i) - ADDR_BYTE0);
    rd_low   = rd && (int'(haddr_i) == ADDR_BYTE0 + NBYTES - 1);
  end

  hp_regs #(.DATA_W(DATA_W), .VEC_RESET(VEC_RESET)) u_regs (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .soft_i    (soft_rst_i),
    .wr_ctrl_i (wr && int'(haddr_i) == ADDR_CTRL),
    .wr_vec_i  (wr && int'(haddr_i) == ADDR_VEC),
    .wdata_i   (hd_i),
    .rx_en_o   (rx_en),
    .tx_en_o   (tx_en),
    .mode_o    (mode),
    .vec_o     (vec_w)
  );

  hp_data #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_data (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .rx_load_i  (core_rx_load_i),
    .rx_word_i  (core_rx_word_i),
    .tx_take_i  (core_tx_take_i),
    .wr_byte_i  (wr && in_bytes),
    .byte_idx_i (byte_idx),
    .wdata_i    (hd_i),
    .rd_low_i   (rd_low),
    .rx_word_o  (rx_word),
    .tx_word_o  (core_tx_word_o),
    .rxdf_o     (rxdf_w),
    .txde_o     (txde_w)
  );

  hp_bus #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bus (
    .rx_en_i   (rx_en),
    .tx_en_i   (tx_en),
    .mode_i    (mode),
    .rxdf_i    (rxdf_w),
    .txde_i    (txde_w),
    .vec_i     (vec_w),
    .rx_word_i (rx_word),
    .addr_i    (haddr_i),
    .rd_cyc_i  (hcs_i && hrw_i),
    .hack_i    (hack_i),
    .hd_o      (hd_o),
    .hd_oe_o   (hd_oe_o),
    .req_o     (host_req_o),
    .dma_o     (dma_w)
  );
endmodule

// File: rtl/hp_status_chk.sv
module hp_status_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              indiv_rst_i,
  input logic              stop_i,
  input logic              hcs_i,
  input logic              hstb_i,
  input logic              hrw_i,
  input logic [ADDR_W-1:0] haddr_i,
  input logic              hack_i,
  input logic              core_rx_load_i,
  input logic              core_tx_take_i,
  input logic              host_req_o,
  input logic              hd_oe_o,
  input logic [DATA_W-1:0] hd_o,
  input logic              dma_i,
  input logic [DATA_W-1:0] vec_i,
  input logic              rxdf_i,
  input logic              txde_i
);
  wire any_clr = soft_rst_i || indiv_rst_i || stop_i;
  wire ack_on  = hack_i && host_req_o && !dma_i;

  AST_CLR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_clr |=> (!host_req_o && !dma_i && !rxdf_i && txde_i)); // R6
  AST_VEC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((indiv_rst_i || stop_i) && !soft_rst_i) |=> $stable(vec_i)); // R6
  AST_SOFT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (vec_i == VEC_RESET)); // R5
  AST_VEC_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_on |-> (hd_oe_o && hd_o == vec_i)); // R7
  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(hcs_i && hrw_i) && !ack_on) |-> !hd_oe_o); // R8
  AST_RXDF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rx_load_i && !any_clr) |=> rxdf_i); // R3
  AST_RXDF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcs_i && hstb_i && hrw_i && int'(haddr_i) == 5 && !core_rx_load_i) |=> !rxdf_i); // R3
  AST_TXDE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_tx_take_i |=> txde_i); // R4
endmodule

bind hp_status_top hp_status_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_RESET(VEC_RESET)) u_chk (
  .clk_i, .rst_ni, .soft_rst_i, .indiv_rst_i, .stop_i,
  .hcs_i, .hstb_i, .hrw_i, .haddr_i, .hack_i,
  .core_rx_load_i, .core_tx_take_i,
  .host_req_o, .hd_oe_o, .hd_o,
  .dma_i  (dma_w),
  .vec_i  (vec_w),
  .rxdf_i (rxdf_w),
  .txde_i (txde_w)
);

// File: tb/tb_hp_status_top.sv
module tb_hp_status_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, indiv_rst = 0, stop = 0;
  logic hcs = 0, hstb = 0, hrw = 0, hack = 0;
  logic [2:0] haddr = '0;
  logic [7:0] hd_in = '0, hd_out;
  logic hd_oe, host_req;
  logic rx_load = 0, tx_take = 0;
  logic [23:0] rx_word = '0, tx_word;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  hp_status_top dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .indiv_rst_i(indiv_rst),
    .stop_i(stop), .hcs_i(hcs), .hstb_i(hstb), .hrw_i(hrw), .haddr_i(haddr),
    .hd_i(hd_in), .hd_o(hd_out), .hd_oe_o(hd_oe), .hack_i(hack),
    .host_req_o(host_req), .core_rx_load_i(rx_load), .core_rx_word_i(rx_word),
    .core_tx_take_i(tx_take), .core_tx_word_o(tx_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design presents it
  always @(negedge clk) begin
    if (hcs && hrw && hstb) begin
      if (exp_q.size() == 0) check("monitor queue empty", 1, 0);
      else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " data"}, {24'h0, hd_out}, {24'h0, e});
        check("R8 oe during read", {31'h0, hd_oe}, 1);
      end
    end
  end

  task automatic host_read(input int a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    hcs = 1; hrw = 1; hstb = 1; haddr = 3'(a);
    @(posedge clk); #1;
    hcs = 0; hrw = 0; hstb = 0;
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    hcs = 1; hrw = 0; hstb = 1; haddr = 3'(a); hd_in = d;
    @(posedge clk); #1;
    hcs = 0; hstb = 0;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: rx_load = 1; 1: tx_take = 1; 2: soft_rst = 1;
      3: indiv_rst = 1; default: stop = 1;
    endcase
    @(posedge clk); #1;
    rx_load = 0; tx_take = 0; soft_rst = 0; indiv_rst = 0; stop = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R8 reset oe", {31'h0, hd_oe}, 0);
    check("R2 reset req", {31'h0, host_req}, 0);
    host_read(1, 8'h02, "R4 reset status");
    host_read(2, 8'h0F, "R5 reset vector");
    host_read(0, 8'h00, "R6 reset ctrl");

    host_write(2, 8'hA5);
    host_read(2, 8'hA5, "R5 vector rw");

    host_write(0, 8'h02);                     // tx enable
    check("R2 tx req", {31'h0, host_req}, 1);
    host_read(1, 8'h82, "R2 status req");

    @(posedge clk); #1 hack = 1;
    #2 check("R7 ack oe", {31'h0, hd_oe}, 1);
    check("R7 ack vector", {24'h0, hd_out}, 32'hA5);
    @(posedge clk); #1 hack = 0;
    #2 check("R8 idle oe", {31'h0, hd_oe}, 0);

    host_write(0, 8'h0A);                     // tx en + mode bit 0
    host_read(1, 8'hC2, "R1 dma hm0");
    @(posedge clk); #1 hack = 1;
    #2 check("R7 no drive in dma", {31'h0, hd_oe}, 0);
    @(posedge clk); #1 hack = 0;
    host_write(0, 8'h12);                     // mode bit 1
    host_read(1, 8'hC2, "R1 dma hm1");
    host_write(0, 8'h02);
    host_read(1, 8'h82, "R1 dma off");

    host_write(3, 8'h11);
    host_write(4, 8'h22);
    check("R4 txde kept before low", {31'h0, host_req}, 1);
    host_write(5, 8'h33);
    check("R4 low write clears", {31'h0, host_req}, 0);
    check("R4 tx word", {8'h0, tx_word}, 32'h112233);
    host_read(1, 8'h00, "R4 status empty clr");
    pulse(1);
    check("R4 take sets", {31'h0, host_req}, 1);

    host_write(0, 8'h01);                     // rx enable only
    check("R2 rx en no data", {31'h0, host_req}, 0);
    rx_word = 24'hABCDEF;
    pulse(0);
    check("R3 load req", {31'h0, host_req}, 1);
    host_read(1, 8'h83, "R3 status full");
    host_read(3, 8'hAB, "R9 high byte");
    host_read(4, 8'hCD, "R9 mid byte");
    host_read(1, 8'h83, "R3 not cleared early");
    host_write(3, 8'h55);
    host_read(3, 8'hAB, "R9 write ignored");
    host_read(5, 8'hEF, "R9 low byte");
    host_read(1, 8'h02, "R3 low read clears");
    check("R3 req off", {31'h0, host_req}, 0);

    host_write(0, 8'h0B);
    pulse(0);
    pulse(3);
    check("R6 indiv req", {31'h0, host_req}, 0);
    host_read(0, 8'h00, "R6 indiv ctrl");
    host_read(1, 8'h02, "R6 indiv status");
    host_read(2, 8'hA5, "R6 indiv vector kept");

    host_write(0, 8'h13);
    pulse(0);
    pulse(4);
    host_read(1, 8'h02, "R6 stop status");
    host_read(2, 8'hA5, "R6 stop vector kept");

    host_write(0, 8'h0B);
    pulse(2);
    host_read(1, 8'h02, "R6 soft status");
    host_read(2, 8'h0F, "R5 soft vector");

    host_write(2, 8'h3C);
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    host_read(2, 8'h0F, "R5 hw vector");

    repeat (2) @(posedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule